// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block decides which of four DMA channels may use the bus when several of them raise a transfer request at once. A two-bit mode input chooses the ranking scheme. Two schemes use a constant ranking. A plain rotating scheme starts from the same ranking as mode 00. A second rotating scheme, meant for channels whose requests arrive on external pins, starts from a strictly descending ranking.

Once a channel is granted, it keeps the grant until the transfer-complete strobe arrives. Arbitration then runs again on the following clock edge. In the rotating schemes the channel that has just finished drops to the bottom of the ranking, and the other channels keep their order relative to each other. The rotation state changes only when a transfer completes. When the mode field changes while no grant is active, that state is reloaded with the starting ranking of the new mode.

The grant appears both as a one-hot vector and as an encoded channel number with a valid flag.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After synchronous reset, `grant` is 0, `grant_valid` is 0, `grant_id` is 0, and the stored mode is 00.
- R2: Mode 2'b00 is a constant ranking, from highest to lowest: channel 0, channel 3, channel 2, channel 1.
- R3: Mode 2'b01 is a constant ranking, from highest to lowest: channel 1, channel 3, channel 2, channel 0.
- R4: Mode 2'b10 is rotating. Its starting ranking is 0, 3, 2, 1, from highest to lowest.
- R5: Mode 2'b11 is rotating. Its starting ranking is 3, 2, 1, 0, from highest to lowest.
- R6: In modes 2'b10 and 2'b11, a completed transfer moves the granted channel to the lowest rank, and the remaining channels keep their relative order. The ranking changes at no other time.
- R7: While idle, a request sampled at a clock edge produces the grant right after that edge. A lone request is granted whatever its rank.
- R8: The grant stays unchanged, whatever `req` and `mode` do, until `done` is sampled high. The grant clears at that edge, and a new grant can appear at the next edge.
- R9: `done` sampled while no grant is active has no effect on the grant or on the ranking.
- R10: A mode change sampled while idle reloads the ranking with the starting ranking of the new mode.
- R11: When no channel requests while idle, the next cycle shows `grant` = 0 and `grant_valid` = 0.
- R12: `grant` is one-hot or zero. It is nonzero exactly when `grant_valid` is 1, and then bit `grant_id` is the set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 4 | Transfer request, one bit per channel |
| mode | input | 2 | Ranking scheme: 00 and 01 constant, 10 rotating, 11 pin-driven rotating |
| done | input | 1 | Transfer-complete strobe for the granted channel |
| grant | output | 4 | One-hot grant vector |
| grant_id | output | 2 | Number of the granted channel |
| grant_valid | output | 1 | The grant outputs are meaningful |

## Verification
All four channels requesting at once is the pattern that exposes a ranking. Requesters are then removed from the top one at a time, which shows each position of the constant orders, including their out-of-sequence middle ranks. Long runs of full requests in the rotating modes separate true demotion of the finished channel from a plain shift. A partial request set in the middle of a rotating run shows that the other channels keep their relative order. Further scenarios cover a lone low-rank request, a strobe while idle, mode changes both while busy and while idle, and request changes during a held grant, to separate the hold, the ignore and the reload behaviour.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int NCH = 4;
    localparam int CW  = $clog2(NCH);

    typedef logic [CW-1:0]     ch_t;
    typedef ch_t  [NCH-1:0]    order_t;   // index 0 = highest rank
    typedef logic [NCH-1:0]    vec_t;

    typedef enum logic [1:0] {
        MODE_FIX_A = 2'b00,
        MODE_FIX_B = 2'b01,
        MODE_ROT   = 2'b10,
        MODE_ROT_X = 2'b11
    } mode_e;

    function automatic logic is_rotating(mode_e m);
        return m[1];
    endfunction

    // Starting ranking for each scheme
    function automatic order_t start_order(mode_e m);
        order_t r;
        for (int i = 0; i < NCH; i++) begin
            unique case (m)
                MODE_FIX_A, MODE_ROT:
                    r[i] = (i == 0) ? ch_t'(0) : ch_t'(NCH - i);
                MODE_FIX_B:
                    if (i == 0)            r[i] = ch_t'(1);
                    else if (i == NCH - 1) r[i] = ch_t'(0);
                    else                   r[i] = ch_t'(NCH - i);
                default:
                    r[i] = ch_t'(NCH - 1 - i);
            endcase
        end
        return r;
    endfunction

    // Move channel c to the lowest rank, keep others in order
    function automatic order_t demote(order_t o, ch_t c);
        order_t r;
        logic   seen;
        seen = 1'b0;
        for (int i = 0; i < NCH - 1; i++) begin
            seen = seen | (o[i] == c);
            r[i] = seen ? o[i+1] : o[i];
        end
        r[NCH-1] = c;
        return r;
    endfunction

    function automatic vec_t to_onehot(ch_t c);
        vec_t v;
        v = '0;
        v[c] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/arb_order_reg.sv
module arb_order_reg
    import arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  mode_e  mode,
    input  logic   idle,
    input  logic   fin,
    input  ch_t    fin_ch,
    output order_t eff_order
);
    mode_e  mode_q;
    order_t rank_q;
    logic   mode_moved;

    assign mode_moved = (mode != mode_q);

    always_comb begin
        if (mode_moved || !is_rotating(mode))
            eff_order = start_order(mode);
        else
            eff_order = rank_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_FIX_A;
            rank_q <= start_order(MODE_FIX_A);
        end else if (idle && mode_moved) begin
            mode_q <= mode;
            rank_q <= start_order(mode);
        end else if (fin && is_rotating(mode_q)) begin
            rank_q <= demote(rank_q, fin_ch);
        end
    end
endmodule

// File: rtl/arb_select.sv
module arb_select
    import arb_pkg::*;
(
    input  vec_t   req,
    input  order_t order,
    output logic   hit,
    output ch_t    win
);
    vec_t by_rank;

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_rank
            assign by_rank[g] = req[order[g]];
        end
    endgenerate

    always_comb begin
        hit = |by_rank;
        win = order[0];
        for (int i = NCH - 1; i >= 0; i--) begin
            if (by_rank[i]) win = order[i];
        end
    end
endmodule

// File: rtl/arb_grant_reg.sv
module arb_grant_reg
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  ch_t  win,
    input  logic done,
    output logic valid,
    output ch_t  id
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            id    <= '0;
        end else if (valid) begin
            if (done) begin
                valid <= 1'b0;
                id    <= '0;
            end
        end else if (hit) begin
            valid <= 1'b1;
            id    <= win;
        end
    end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
    import arb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req,
    input  logic [1:0]     mode,
    input  logic           done,
    output logic [NCH-1:0] grant,
    output logic [CW-1:0]  grant_id,
    output logic           grant_valid
);
    order_t eff_order;
    logic   hit;
    ch_t    win;
    logic   valid_q;
    ch_t    id_q;

    arb_order_reg u_order (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_e'(mode)),
        .idle      (!valid_q),
        .fin       (valid_q && done),
        .fin_ch    (id_q),
        .eff_order (eff_order)
    );

    arb_select u_sel (
        .req   (req),
        .order (eff_order),
        .hit   (hit),
        .win   (win)
    );

    arb_grant_reg u_gnt (
        .clk   (clk),
        .rst   (rst),
        .hit   (hit),
        .win   (win),
        .done  (done),
        .valid (valid_q),
        .id    (id_q)
    );

    assign grant       = valid_q ? to_onehot(id_q) : '0;
    assign grant_id    = id_q;
    assign grant_valid = valid_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker
    import arb_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] req,
    input logic [1:0]     mode,
    input logic           done,
    input logic [NCH-1:0] grant,
    input logic [CW-1:0]  grant_id,
    input logic           grant_valid
);
    p_onehot_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant != '0) == grant_valid));

    p_id_match_r12: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> grant[grant_id]);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !done) |=> ($stable(grant) && grant_valid));

    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && done) |=> !grant_valid);

    p_take_r7: assert property (@(posedge clk) disable iff (rst)
        (!grant_valid && (req != '0)) |=> grant_valid);

    p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!grant_valid && (req == '0)) |=> !grant_valid);

    p_top_fix_a_r2: assert property (@(posedge clk) disable iff (rst)
        (!grant_valid && mode == 2'b00 && req[0]) |=> (grant_id == '0));
endmodule

bind dma_prio_arbiter arb_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .mode        (mode),
    .done        (done),
    .grant       (grant),
    .grant_id    (grant_id),
    .grant_valid (grant_valid)
);

// File: tb/dma_prio_arbiter_tb.sv
module dma_prio_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] req;
    logic [1:0] mode;
    logic       done;
    logic [3:0] grant;
    logic [1:0] grant_id;
    logic       grant_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_prio_arbiter dut_i (
        .clk(clk), .rst(rst), .req(req), .mode(mode), .done(done),
        .grant(grant), .grant_id(grant_id), .grant_valid(grant_valid)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_grant(input int ch, input string tag);
        chk(grant_valid == 1'b1, {tag, " valid"}, grant_valid, 1);
        chk(grant_id == ch[1:0], {tag, " id"}, grant_id, ch);
        chk(grant == (4'b1 << ch), {tag, " onehot R12"}, grant, 4'b1 << ch);
    endtask

    task automatic expect_idle(input string tag);
        chk(grant_valid == 1'b0 && grant == 4'b0, tag, {grant_valid, grant}, 0);
    endtask

    // present requests, check grant, complete it
    task automatic grant_and_finish(input logic [3:0] r, input int ch, input string tag);
        req = r;
        step();
        expect_grant(ch, tag);
        done = 1'b1;
        step();
        done = 1'b0;
        expect_idle({tag, " release R8"});
    endtask

    task automatic set_mode_idle(input logic [1:0] m);
        req  = 4'b0;
        mode = m;
        step();
    endtask

    task automatic t_reset();
        expect_idle("R1 reset outputs");
        chk(grant_id == 2'd0, "R1 reset id", grant_id, 0);
        req = 4'b0;
        step();
        expect_idle("R11 no request");
    endtask

    task automatic t_fixed_a();
        set_mode_idle(2'b00);
        grant_and_finish(4'b1111, 0, "R2 rank0");
        grant_and_finish(4'b1110, 3, "R2 rank1");
        grant_and_finish(4'b0110, 2, "R2 rank2");
        grant_and_finish(4'b0010, 1, "R2 rank3");
    endtask

    task automatic t_fixed_b();
        set_mode_idle(2'b01);
        grant_and_finish(4'b1111, 1, "R3 rank0");
        grant_and_finish(4'b1101, 3, "R3 rank1");
        grant_and_finish(4'b0101, 2, "R3 rank2");
        grant_and_finish(4'b0001, 0, "R3 rank3");
        grant_and_finish(4'b1111, 1, "R3 no rotation");
    endtask

    task automatic t_rot();
        set_mode_idle(2'b10);
        grant_and_finish(4'b1111, 0, "R4 start");
        grant_and_finish(4'b1111, 3, "R6 rot1");
        grant_and_finish(4'b1111, 2, "R6 rot2");
        grant_and_finish(4'b1111, 1, "R6 rot3");
        grant_and_finish(4'b1111, 0, "R6 wrap");
        // ranking now 3,2,1,0
        grant_and_finish(4'b0110, 2, "R6 partial");
        // ranking now 3,1,0,2
        grant_and_finish(4'b1111, 3, "R6 keep order a");
        // ranking now 1,0,2,3
        grant_and_finish(4'b1101, 0, "R6 keep order b");
    endtask

    task automatic t_rot_x();
        set_mode_idle(2'b11);
        grant_and_finish(4'b1111, 3, "R5 start");
        grant_and_finish(4'b1111, 2, "R5 rot1");
        grant_and_finish(4'b0011, 1, "R5 rot2");
    endtask

    task automatic t_reload();
        // go to constant mode then back: rotating state restarts
        set_mode_idle(2'b00);
        set_mode_idle(2'b11);
        grant_and_finish(4'b1111, 3, "R10 reload x");
        set_mode_idle(2'b10);
        grant_and_finish(4'b1111, 0, "R10 reload rot");
    endtask

    task automatic t_lone();
        set_mode_idle(2'b00);
        req = 4'b0010;
        step();
        expect_grant(1, "R7 lone low rank");
        done = 1'b1;
        step();
        done = 1'b0;
        req = 4'b0;
        step();
        expect_idle("R11 after lone");
    endtask

    task automatic t_hold();
        set_mode_idle(2'b00);
        req = 4'b0100;
        step();
        expect_grant(2, "R8 hold start");
        req = 4'b0001;
        mode = 2'b01;
        step();
        step();
        expect_grant(2, "R8 hold under change");
        req = 4'b0;
        step();
        expect_grant(2, "R8 hold req dropped");
        done = 1'b1;
        step();
        done = 1'b0;
        expect_idle("R8 cleared");
        set_mode_idle(2'b00);
    endtask

    task automatic t_idle_done();
        set_mode_idle(2'b00);
        set_mode_idle(2'b10);
        done = 1'b1;
        step();
        done = 1'b0;
        expect_idle("R9 strobe idle");
        grant_and_finish(4'b1111, 0, "R9 ranking untouched");
    endtask

    initial begin
        rst = 1'b1; req = 4'b0; mode = 2'b00; done = 1'b0;
        step();
        step();
        rst = 1'b0;
        t_reset();
        t_fixed_a();
        t_fixed_b();
        t_rot();
        t_rot_x();
        t_reload();
        t_lone();
        t_hold();
        t_idle_done();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule